// File: doc/BRIEF.md
# Three-Wire Serial Control Register

This block holds the 20-bit configuration word of a full-bridge motor-drive controller. Software loads the word over a three-line port made of a serial clock, a data line and a strobe. The strobe rests high and goes low to open a write. Each rising serial clock shifts in one bit, starting with bit 19. When the strobe goes high again, the word becomes the active configuration, but only if exactly 20 bits arrived during the write.

All port lines are sampled in the system clock domain through two-flop synchronisers. The ENABLE, PHASE, MODE and RANGE pins are synchronised the same way. Four stored bits do not drive an output directly. Each is compared with one of these pins, so software sets the active polarity of that pin. The block decodes the timer codes, the synchronous-rectification controls and the decay selection from the active word. It also holds off the drive until the block has been out of sleep for a settle interval. An active-low undervoltage reset clears the stored word to zero at any time.

Top module: `serial_ctrl_reg`

## Requirements
- R1: After reset the active word is all zeros. sleep is 1, driveOn is 0, every code and setting output is 0, and the pin-resolved outputs follow their rules with stored bits of 0.
- R2: Bits are shifted in MSB first. From the active word, blankCode is bits 1:0, offCode is bits 6:2 and fastCode is bits 10:7.
- R3: srPassive is bit 11 (0 active, 1 passive), srEnable is bit 12, and extSlow is bit 13 (0 fast, 1 slow decay for external chopping).
- R4: The active word does not change while the strobe is low. A new word takes effect only after the strobe returns high.
- R5: A write with fewer or more than 20 rising serial clocks leaves the active word unchanged.
- R6: Once settled, driveOn is 1 when the synchronised ENABLE differs from bit 14 and 0 (chopped) when they are equal. driveOn is always 0 in sleep.
- R7: dirFwd is 1 (forward) when the synchronised PHASE differs from bit 15 and 0 (reverse) when they are equal.
- R8: decaySlow is 1 when MODE differs from bit 17 and 0 (mixed) when they are equal. rangeDiv5 is 1 when RANGE differs from bit 16 and 0 (divide-by-10 scale) when they are equal.
- R9: sleep is the inverse of bit 19, and testBit is bit 18.
- R10: driveOn stays 0 until bit 19 has been 1 for SETTLE_CYC system clocks. Returning to sleep restarts the interval.
- R11: Pulling uvRstN low at any time clears the active word to zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| uvRstN | input | 1 | Asynchronous active-low undervoltage/power-up reset |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, MSB first |
| serStb | input | 1 | Strobe, idle high, low during a write |
| enPin | input | 1 | ENABLE pin level |
| phPin | input | 1 | PHASE pin level |
| mdPin | input | 1 | MODE pin level |
| rgPin | input | 1 | RANGE pin level |
| blankCode | output | 2 | Blanking-time code |
| offCode | output | 5 | Fixed off-time code |
| fastCode | output | 4 | Fast-decay portion code |
| srPassive | output | 1 | Synchronous rectification passive mode |
| srEnable | output | 1 | Synchronous rectification enable |
| extSlow | output | 1 | Slow decay for external chopping |
| driveOn | output | 1 | Bridge drive on (0 = chopped) |
| dirFwd | output | 1 | Forward direction |
| decaySlow | output | 1 | Slow decay (0 = mixed) |
| rangeDiv5 | output | 1 | Higher current-range scale selected |
| testBit | output | 1 | Stored test bit |
| sleep | output | 1 | Sleep state |

## Verification
The hardest case to reach from the ports is a write with the wrong length. It must leave the active word untouched, even though the shift register has already taken in new bits. The bench sends frames of 19 and 21 clocks, each carrying a word that differs in every field, and confirms that every output keeps its earlier value. It also samples the outputs halfway through a valid write, before the strobe rises. The settle interval is reached by shortening SETTLE_CYC and checking driveOn once before the count completes and once after.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int WORD_W = 20;
  localparam int BIT_SRMODE = 11;
  localparam int BIT_SREN   = 12;
  localparam int BIT_EXTDEC = 13;
  localparam int BIT_ENPOL  = 14;
  localparam int BIT_PHPOL  = 15;
  localparam int BIT_RGPOL  = 16;
  localparam int BIT_MDPOL  = 17;
  localparam int BIT_TEST   = 18;
  localparam int BIT_AWAKE  = 19;

  typedef struct packed {
    logic shiftEn;
    logic dataBit;
    logic load;
  } sctlStb_t;
endpackage

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int WORDW = WORD_W
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     serClk,
  input  logic     serData,
  input  logic     serStb,
  output sctlStb_t stb
);
  localparam int CNT_W = $clog2(WORDW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORDW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORDW + 1);

  logic [2:0] clkSh, stbSh;
  logic [1:0] datSh;
  logic [CNT_W-1:0] bitCnt;
  logic clkRise, stbFall, stbRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSh <= 3'b000;
      stbSh <= 3'b111;
      datSh <= 2'b00;
    end else begin
      clkSh <= {clkSh[1:0], serClk};
      stbSh <= {stbSh[1:0], serStb};
      datSh <= {datSh[0], serData};
    end
  end

  assign clkRise = clkSh[1] & ~clkSh[2];
  assign stbFall = ~stbSh[1] & stbSh[2];
  assign stbRise = stbSh[1] & ~stbSh[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (stbFall) bitCnt <= '0;
    else if (clkRise && !stbSh[1] && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    stb.shiftEn = clkRise & ~stbSh[1];
    stb.dataBit = datSh[1];
    stb.load    = stbRise & (bitCnt == CNT_FULL);
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_SAT);
  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stbFall |=> bitCnt == '0);
endmodule

// File: rtl/sctl_dpath.sv
module sctl_dpath
  import sctl_pkg::*;
#(
  parameter int WORDW      = WORD_W,
  parameter int SETTLE_CYC = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  sctlStb_t   stb,
  input  logic       enPin,
  input  logic       phPin,
  input  logic       mdPin,
  input  logic       rgPin,
  output logic [1:0] blankCode,
  output logic [4:0] offCode,
  output logic [3:0] fastCode,
  output logic       srPassive,
  output logic       srEnable,
  output logic       extSlow,
  output logic       driveOn,
  output logic       dirFwd,
  output logic       decaySlow,
  output logic       rangeDiv5,
  output logic       testBit,
  output logic       sleep
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SET_W-1:0] SET_MAX = SET_W'(SETTLE_CYC);
  localparam int NPIN = 4;

  logic [WORDW-1:0] shiftWord, actWord;
  logic [NPIN-1:0] pinRaw, pinSync;
  logic [SET_W-1:0] settleCnt;
  logic awake, settled;

  assign pinRaw = {rgPin, mdPin, phPin, enPin};

  for (genvar g = 0; g < NPIN; g++) begin : g_pinSync
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= 2'b00;
      else       stage <= {stage[0], pinRaw[g]};
    end
    assign pinSync[g] = stage[1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      actWord   <= '0;
    end else begin
      if (stb.shiftEn) shiftWord <= {shiftWord[WORDW-2:0], stb.dataBit};
      if (stb.load)    actWord   <= shiftWord;
    end
  end

  assign awake = actWord[BIT_AWAKE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 settleCnt <= '0;
    else if (!awake)           settleCnt <= '0;
    else if (settleCnt != SET_MAX) settleCnt <= settleCnt + 1'b1;
  end
  assign settled = awake && (settleCnt == SET_MAX);

  always_comb begin
    blankCode = actWord[1:0];
    offCode   = actWord[6:2];
    fastCode  = actWord[10:7];
    srPassive = actWord[BIT_SRMODE];
    srEnable  = actWord[BIT_SREN];
    extSlow   = actWord[BIT_EXTDEC];
    driveOn   = settled & (pinSync[0] ^ actWord[BIT_ENPOL]);
    dirFwd    = pinSync[1] ^ actWord[BIT_PHPOL];
    decaySlow = pinSync[2] ^ actWord[BIT_MDPOL];
    rangeDiv5 = pinSync[3] ^ actWord[BIT_RGPOL];
    testBit   = actWord[BIT_TEST];
    sleep     = ~awake;
  end

  // R4
  load_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(actWord));
  // R6
  drive_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !driveOn);
  // R10
  settle_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(settled) |-> $past(awake));
  // R10
  settle_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !awake |=> settleCnt == '0);
endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg
  import sctl_pkg::*;
#(
  parameter int SETTLE_CYC = 100000
) (
  input  logic       clk,
  input  logic       uvRstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serStb,
  input  logic       enPin,
  input  logic       phPin,
  input  logic       mdPin,
  input  logic       rgPin,
  output logic [1:0] blankCode,
  output logic [4:0] offCode,
  output logic [3:0] fastCode,
  output logic       srPassive,
  output logic       srEnable,
  output logic       extSlow,
  output logic       driveOn,
  output logic       dirFwd,
  output logic       decaySlow,
  output logic       rangeDiv5,
  output logic       testBit,
  output logic       sleep
);
  sctlStb_t stb;

  sctl_ctrl #(.WORDW(WORD_W)) u_ctrl (
    .clk(clk), .rstN(uvRstN), .serClk(serClk), .serData(serData),
    .serStb(serStb), .stb(stb)
  );

  sctl_dpath #(.WORDW(WORD_W), .SETTLE_CYC(SETTLE_CYC)) u_dpath (
    .clk(clk), .rstN(uvRstN), .stb(stb),
    .enPin(enPin), .phPin(phPin), .mdPin(mdPin), .rgPin(rgPin),
    .blankCode(blankCode), .offCode(offCode), .fastCode(fastCode),
    .srPassive(srPassive), .srEnable(srEnable), .extSlow(extSlow),
    .driveOn(driveOn), .dirFwd(dirFwd), .decaySlow(decaySlow),
    .rangeDiv5(rangeDiv5), .testBit(testBit), .sleep(sleep)
  );
endmodule

// File: tb/tb_serial_ctrl_reg.sv
`timescale 1ns/1ps
module tb_serial_ctrl_reg;
  localparam int SETTLE = 20;

  logic clk = 0;
  logic uvRstN = 0;
  logic serClk = 0, serData = 0, serStb = 1;
  logic enPin = 0, phPin = 0, mdPin = 0, rgPin = 0;
  logic [1:0] blankCode;
  logic [4:0] offCode;
  logic [3:0] fastCode;
  logic srPassive, srEnable, extSlow, driveOn, dirFwd, decaySlow, rangeDiv5, testBit, sleep;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  serial_ctrl_reg #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .uvRstN(uvRstN), .serClk(serClk), .serData(serData), .serStb(serStb),
    .enPin(enPin), .phPin(phPin), .mdPin(mdPin), .rgPin(rgPin),
    .blankCode(blankCode), .offCode(offCode), .fastCode(fastCode),
    .srPassive(srPassive), .srEnable(srEnable), .extSlow(extSlow),
    .driveOn(driveOn), .dirFwd(dirFwd), .decaySlow(decaySlow),
    .rangeDiv5(rangeDiv5), .testBit(testBit), .sleep(sleep)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [31:0] val, input int n);
    serStb = 0;
    waitClk(4);
    for (int i = n - 1; i >= 0; i--) begin
      serData = val[i];
      waitClk(3);
      serClk = 1;
      waitClk(3);
      serClk = 0;
    end
    waitClk(3);
    serStb = 1;
    waitClk(6);
  endtask

  task automatic writeWord(input logic [19:0] w);
    sendBits({12'b0, w}, 20);
  endtask

  // full comparison of outputs against a word and current pins (driveOn excluded)
  task automatic checkWord(input string ctx, input logic [19:0] w);
    check({ctx, " R2 blank"}, 32'(blankCode), 32'(w[1:0]));
    check({ctx, " R2 off"},   32'(offCode),   32'(w[6:2]));
    check({ctx, " R2 fast"},  32'(fastCode),  32'(w[10:7]));
    check({ctx, " R3 srPassive"}, 32'(srPassive), 32'(w[11]));
    check({ctx, " R3 srEnable"},  32'(srEnable),  32'(w[12]));
    check({ctx, " R3 extSlow"},   32'(extSlow),   32'(w[13]));
    check({ctx, " R7 dirFwd"},    32'(dirFwd),    32'(phPin != w[15]));
    check({ctx, " R8 decaySlow"}, 32'(decaySlow), 32'(mdPin != w[17]));
    check({ctx, " R8 rangeDiv5"}, 32'(rangeDiv5), 32'(rgPin != w[16]));
    check({ctx, " R9 testBit"},   32'(testBit),   32'(w[18]));
    check({ctx, " R9 sleep"},     32'(sleep),     32'(!w[19]));
  endtask

  task automatic testReset();
    checkWord("reset R1", 20'h0);
    check("reset R1 driveOn", 32'(driveOn), 32'h0);
  endtask

  task automatic testFields();
    logic [19:0] pats [4] = '{20'hA5A5A, 20'h5A5A5, 20'hFFFFF, 20'h80000};
    foreach (pats[i]) begin
      writeWord(pats[i]);
      checkWord("fields", pats[i]);
    end
  endtask

  task automatic testPins();
    logic [19:0] w = 20'h80000 | 20'h0C000 ^ 20'h04000 | 20'h20000;
    writeWord(w);
    for (int p = 0; p < 16; p++) begin
      {rgPin, mdPin, phPin, enPin} = 4'(p);
      waitClk(SETTLE + 5);
      checkWord("pins", w);
      check("pins R6 driveOn", 32'(driveOn), 32'(enPin != w[14]));
    end
    enPin = 0; phPin = 0; mdPin = 0; rgPin = 0;
    waitClk(4);
  endtask

  task automatic testMidWrite();
    logic [19:0] oldW = 20'h9_3C21;
    logic [19:0] newW = 20'h6_C3DE;
    writeWord(oldW);
    serStb = 0;
    waitClk(4);
    for (int i = 19; i >= 0; i--) begin
      serData = newW[i];
      waitClk(3);
      serClk = 1;
      waitClk(3);
      serClk = 0;
    end
    waitClk(10);
    checkWord("midwrite R4 strobe low", oldW);
    serStb = 1;
    waitClk(6);
    checkWord("midwrite R4 after strobe", newW);
  endtask

  task automatic testBadCount();
    logic [19:0] keep = 20'hB_1234;
    writeWord(keep);
    sendBits(32'h0004_EDCB, 19);
    checkWord("short R5", keep);
    sendBits(32'h0014_EDCB, 21);
    checkWord("long R5", keep);
  endtask

  task automatic testSettle();
    writeWord(20'h00000);
    enPin = 1;
    waitClk(4);
    check("settle R10 asleep", 32'(driveOn), 32'h0);
    writeWord(20'h80000);
    check("settle R10 early", 32'(driveOn), 32'h0);
    waitClk(SETTLE + 5);
    check("settle R10 done", 32'(driveOn), 32'h1);
    writeWord(20'h84000);
    check("settle R6 chopped", 32'(driveOn), 32'h0);
    writeWord(20'h00000);
    check("settle R6 sleep", 32'(driveOn), 32'h0);
    writeWord(20'h80000);
    check("settle R10 restart", 32'(driveOn), 32'h0);
    waitClk(SETTLE + 5);
    check("settle R10 again", 32'(driveOn), 32'h1);
    enPin = 0;
    waitClk(4);
  endtask

  task automatic testUv();
    writeWord(20'hFFFFF);
    uvRstN = 0;
    waitClk(2);
    checkWord("uv R11 held", 20'h0);
    uvRstN = 1;
    waitClk(3);
    checkWord("uv R11 released", 20'h0);
    check("uv R11 driveOn", 32'(driveOn), 32'h0);
  endtask

  initial begin
    waitClk(3);
    uvRstN = 1;
    waitClk(3);
    testReset();
    testFields();
    testPins();
    testMidWrite();
    testBadCount();
    testSettle();
    testUv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule